// File: doc/BRIEF.md
# Four-Channel DMA Stop and Status Controller

This block moves data one unit at a time for up to four DMA channels. Each channel keeps a source pointer, a destination pointer, a remaining-unit count and a control word. Software programs these through a small register port. Each request pulse on a channel's request line lets that channel move one unit. A unit is one read cycle on the bus, followed by one write cycle that stores the read data at the destination. After the unit, both pointers advance by the unit size and the count drops by one.

The block decides when to stop. A single channel stops when its count runs out. It then sets its end flag and, if allowed, raises its interrupt line. A single channel also stops when software clears its enable bit; that case leaves the end flag clear. Every channel stops together when the master enable is off, when the NMI flag is raised, or when a misaligned pointer raises the address-error flag. An address error leaves the channel registers describing the unit that was about to run. It also discards every pending request. The flag can only be cleared by reading it as 1 and then writing 0.

Register index map (reg_addr): channel c uses index 4c+0 for the source pointer, 4c+1 for the destination pointer, 4c+2 for the count and 4c+3 for the control word. Index 16 is the global word.

Top module: `dma_term_ctrl`

## Requirements
- R1: After reset, every channel register and the global word read 0, irq is 0, and bus_rd and bus_wr are low.
- R2: A serviced unit drives one bus_rd cycle at the source pointer, then one bus_wr cycle at the destination pointer carrying the read data. Afterwards both pointers have grown by the unit size and the count has dropped by one. The unit size comes from control bits [4:3]: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes.
- R3: When the unit that takes the count to 0 finishes, control bit 2 (end flag) is set. irq[c] is high exactly when both the end flag and control bit 1 (interrupt enable) are set. A channel whose end flag is set moves no further units.
- R4: A channel whose control bit 0 (enable) is 0 moves no units. Its end flag stays 0, and the other channels keep running.
- R5: While global bit 0 (master enable) is 0, or global bit 2 (NMI flag, set by the nmi input and cleared by writing 0) is 1, no channel starts a unit and no end flag is set. A request latched during that time is served once the stop is lifted.
- R6: If the chosen channel's source or destination pointer is not a multiple of its unit size, global bit 1 (address error) is set instead of running the unit. No bus cycle is made, and that channel's pointers, count and end flag are left unchanged.
- R7: Writing 0 to the address-error bit clears it only when a read of the global word has returned it as 1 since it was set. Otherwise the bit stays 1.
- R8: While the address error is set, request pulses are dropped. Requests pending when the error arises are discarded, so nothing moves after the flag clears until a new request arrives.
- R9: Only one unit is in flight at a time. When several channels are ready, the lowest-numbered channel is served first.
- R10: A unit that has started completes its read, its write and its register update even if its channel's enable bit is cleared partway through.
- R11: Register writes are read back unchanged at the indices above. Only control bits [4:0] and global bits [2:0] exist; every other read bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks the address error as seen) |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dreq | input | 4 | Per-channel request pulses, one unit each |
| nmi | input | 1 | Sets the NMI flag |
| bus_rd | output | 1 | Bus read cycle |
| bus_wr | output | 1 | Bus write cycle |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, sampled during the read cycle |
| irq | output | 4 | Per-channel end-of-transfer interrupt requests |

## Verification
A request pulse is latched at the first rising edge. The unit's read cycle follows at the second edge and its write cycle at the third. The pointers, count, end flag and irq take their new values at the fourth edge. A second ready channel therefore finishes three edges later.

The address-error flag is set on the second edge, and a register write takes effect on the edge it spans. The bench therefore drives every stimulus on a falling edge and then waits a fixed number of falling edges that matches this count before reading values back. A mid-unit enable change is timed so that its write edge falls between the read cycle and the write cycle.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} dma_st_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_IE   = 1;
  localparam int CTL_DONE = 2;
  localparam int CTL_SZ   = 3;
  localparam int GL_DME   = 0;
  localparam int GL_AE    = 1;
  localparam int GL_NMIF  = 2;

  // bytes moved per unit for a size code
  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // true when the low address bits break alignment for the size code
  function automatic logic misaligned(input logic [1:0] lsb, input logic [1:0] sz);
    case (sz)
      2'd0:    return 1'b0;
      2'd1:    return lsb[0];
      default: return lsb != 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_term_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_cnt,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  input  logic          adv,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          en,
  output logic          ie,
  output logic          done,
  output logic [1:0]    sz,
  output logic          last
);
  logic [AW-1:0] step;
  assign step = AW'(unit_bytes(sz));
  assign last = adv && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
    end else if (adv) begin
      src <= src + step;
      dst <= dst + step;
      cnt <= cnt - CW'(1);
    end else begin
      if (wr_src) src <= wdata[AW-1:0];
      if (wr_dst) dst <= wdata[AW-1:0];
      if (wr_cnt) cnt <= wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      ie   <= 1'b0;
      sz   <= 2'd0;
      done <= 1'b0;
    end else begin
      if (wr_ctl) begin
        en <= wdata[CTL_EN];
        ie <= wdata[CTL_IE];
        sz <= wdata[CTL_SZ+1:CTL_SZ];
      end
      done <= last | (done & ~(wr_ctl & ~wdata[CTL_DONE]));
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] ready,
  output logic [NCH-1:0] grant_oh,
  output logic [IW-1:0]  grant_idx,
  output logic           any
);
  always_comb begin
    grant_oh  = '0;
    grant_idx = '0;
    any       = |ready;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (ready[c]) begin
        grant_oh     = '0;
        grant_oh[c]  = 1'b1;
        grant_idx    = IW'(c);
      end
    end
  end
endmodule

// File: rtl/dma_glob_reg.sv
module dma_glob_reg
  import dma_term_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic          ae_set,
  input  logic          nmi,
  output logic          dme,
  output logic          ae,
  output logic          nmif,
  output logic          ae_seen
);
  logic ae_clr;
  assign ae_clr = wr && !wdata[GL_AE] && ae_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dme     <= 1'b0;
      ae      <= 1'b0;
      nmif    <= 1'b0;
      ae_seen <= 1'b0;
    end else begin
      if (wr) dme <= wdata[GL_DME];
      if (ae_set)      ae <= 1'b1;
      else if (ae_clr) ae <= 1'b0;
      if (!ae || ae_clr)  ae_seen <= 1'b0;
      else if (rd)        ae_seen <= 1'b1;
      if (nmi)                       nmif <= 1'b1;
      else if (wr && !wdata[GL_NMIF]) nmif <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl
  import dma_term_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int DW  = 32,
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int GLOB_IDX = NCH * 4,
  localparam int RAW = $clog2(GLOB_IDX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [NCH-1:0] dreq,
  input  logic           nmi,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq
);
  logic [AW-1:0] src [NCH];
  logic [AW-1:0] dst [NCH];
  logic [CW-1:0] cnt [NCH];
  logic [1:0]    sz  [NCH];
  logic [NCH-1:0] en_vec, ie_vec, done_vec, last_vec, adv_vec, armed, pend, ready;
  logic [NCH-1:0] grant_oh, cur_oh;
  logic [IW-1:0]  grant_idx, cur;
  logic           any, misal, unit_start, unit_last, ae_set;
  logic           dme, ae_flag, nmif, ae_seen, go;
  logic           glob_sel;
  logic [DW-1:0]  data_q;
  dma_st_e        st;

  assign glob_sel = reg_addr == RAW'(GLOB_IDX);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_src(reg_wr && reg_addr == RAW'(c*4)),
      .wr_dst(reg_wr && reg_addr == RAW'(c*4+1)),
      .wr_cnt(reg_wr && reg_addr == RAW'(c*4+2)),
      .wr_ctl(reg_wr && reg_addr == RAW'(c*4+3)),
      .wdata(reg_wdata), .adv(adv_vec[c]),
      .src(src[c]), .dst(dst[c]), .cnt(cnt[c]),
      .en(en_vec[c]), .ie(ie_vec[c]), .done(done_vec[c]),
      .sz(sz[c]), .last(last_vec[c])
    );
    assign armed[c]   = en_vec[c] && !done_vec[c] && (cnt[c] != '0);
    assign adv_vec[c] = (st == ST_WRITE) && (cur == IW'(c));
    assign cur_oh[c]  = (st != ST_IDLE) && (cur == IW'(c));
    assign irq[c]     = done_vec[c] && ie_vec[c];
  end

  dma_glob_reg #(.DW(DW)) u_glob (
    .clk(clk), .rst_n(rst_n),
    .wr(reg_wr && glob_sel), .rd(reg_rd && glob_sel),
    .wdata(reg_wdata), .ae_set(ae_set), .nmi(nmi),
    .dme(dme), .ae(ae_flag), .nmif(nmif), .ae_seen(ae_seen)
  );

  assign go    = dme && !ae_flag && !nmif;
  assign ready = pend & armed & {NCH{go}};

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .ready(ready), .grant_oh(grant_oh), .grant_idx(grant_idx), .any(any)
  );

  assign misal      = misaligned(src[grant_idx][1:0], sz[grant_idx]) ||
                      misaligned(dst[grant_idx][1:0], sz[grant_idx]);
  assign ae_set     = (st == ST_IDLE) && any && misal;
  assign unit_start = (st == ST_IDLE) && any && !misal;
  assign unit_last  = |last_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cur    <= '0;
      data_q <= '0;
      pend   <= '0;
    end else begin
      case (st)
        ST_IDLE:  if (unit_start) begin st <= ST_READ; cur <= grant_idx; end
        ST_READ:  begin data_q <= bus_rdata; st <= ST_WRITE; end
        default:  st <= ST_IDLE;
      endcase
      if (ae_set) pend <= '0;
      else pend <= (pend | (dreq & {NCH{!ae_flag}})) & ~(unit_start ? grant_oh : '0);
    end
  end

  assign bus_rd    = st == ST_READ;
  assign bus_wr    = st == ST_WRITE;
  assign bus_addr  = (st == ST_WRITE) ? dst[cur] : src[cur];
  assign bus_wdata = data_q;

  always_comb begin
    reg_rdata = '0;
    if (glob_sel) reg_rdata[2:0] = {nmif, ae_flag, dme};
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == RAW'(c*4))   reg_rdata = DW'(src[c]);
      if (reg_addr == RAW'(c*4+1)) reg_rdata = DW'(dst[c]);
      if (reg_addr == RAW'(c*4+2)) reg_rdata = DW'(cnt[c]);
      if (reg_addr == RAW'(c*4+3)) reg_rdata = DW'({sz[c], done_vec[c], ie_vec[c], en_vec[c]});
    end
  end
endmodule

// File: rtl/dma_term_chk.sv
module dma_term_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_rd,
  input logic           bus_wr,
  input logic           unit_start,
  input logic           unit_last,
  input logic           ae_set,
  input logic           ae_flag,
  input logic           ae_seen,
  input logic           dme,
  input logic           nmif,
  input logic [NCH-1:0] cur_oh,
  input logic [NCH-1:0] done_vec
);
  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_wr);
  // R9
  one_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr, unit_start}));
  // R3
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_last |=> ((done_vec & $past(cur_oh)) != '0));
  // R5
  global_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dme || nmif) |-> !unit_start);
  // R8
  ae_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ae_flag |-> !unit_start);
  // R6
  ae_nobus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ae_set |=> !bus_rd);
  // R7
  ae_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ae_flag && !ae_seen) |=> ae_flag);
endmodule

bind dma_term_ctrl dma_term_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .unit_start(unit_start), .unit_last(unit_last), .ae_set(ae_set),
  .ae_flag(ae_flag), .ae_seen(ae_seen), .dme(dme), .nmif(nmif),
  .cur_oh(cur_oh), .done_vec(done_vec)
);

// File: tb/test_dma_term_ctrl.sv
module test_dma_term_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  dreq = '0, irq;
  logic        nmi = 1'b0;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int total = 0, bad = 0, wn = 0, rn = 0;
  bit ended = 1'b0;
  logic [15:0] wlog_a [0:63];
  logic [31:0] wlog_d [0:63];

  always #10 clk = ~clk;

  // memory model: read data derived from the address
  assign bus_rdata = {~bus_addr, bus_addr};

  always @(posedge clk) begin
    if (bus_wr) begin
      wlog_a[wn[5:0]] <= bus_addr;
      wlog_d[wn[5:0]] <= bus_wdata;
      wn <= wn + 1;
    end
    if (bus_rd) rn <= rn + 1;
  end

  dma_term_ctrl i_dma_term_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dreq(dreq), .nmi(nmi), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  localparam logic [4:0] GLOB = 5'd16;
  function automatic logic [4:0] ix(input int c, input int k);
    return 5'(c * 4 + k);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); dreq = m;
    @(negedge clk); dreq = '0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 17; i++) begin
      rreg(5'(i), v);
      chk("R1 reg zero", v, 0);
    end
    chk("R1 irq", 32'(irq), 0);
    chk("R1 bus idle", {30'd0, bus_rd, bus_wr}, 0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    int n0;
    wreg(ix(0,0), 32'h100); wreg(ix(0,1), 32'h200);
    wreg(ix(0,2), 32'd2);   wreg(ix(0,3), 32'hFFFF_FF13);
    wreg(GLOB, 32'h1);
    rreg(ix(0,3), v); chk("R11 ctl readback", v, 32'h13);
    rreg(ix(0,1), v); chk("R11 dst readback", v, 32'h200);
    n0 = wn;
    pulse(4'b0001); waitc(3);
    rreg(ix(0,0), v); chk("R2 src step 4", v, 32'h104);
    rreg(ix(0,1), v); chk("R2 dst step 4", v, 32'h204);
    rreg(ix(0,2), v); chk("R2 count", v, 1);
    chk("R2 write addr", 32'(wlog_a[n0[5:0]]), 32'h200);
    chk("R2 write data", wlog_d[n0[5:0]], 32'hFEFF_0100);
    pulse(4'b0001); waitc(3);
    rreg(ix(0,2), v); chk("R3 count zero", v, 0);
    rreg(ix(0,3), v); chk("R3 end flag", v, 32'h17);
    chk("R3 irq ch0", 32'(irq), 32'h1);
    n0 = wn;
    pulse(4'b0001); waitc(3);
    chk("R3 idle after end", wn, n0);
  endtask

  task automatic t_byte;
    logic [31:0] v;
    wreg(ix(2,0), 32'h301); wreg(ix(2,1), 32'h401);
    wreg(ix(2,2), 32'd1);   wreg(ix(2,3), 32'h01);
    pulse(4'b0100); waitc(3);
    rreg(ix(2,0), v); chk("R2 src step 1", v, 32'h302);
    rreg(ix(2,1), v); chk("R2 dst step 1", v, 32'h402);
    rreg(ix(2,3), v); chk("R3 end flag no ie", v, 32'h05);
    chk("R3 irq masked", 32'(irq), 32'h1);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    wreg(ix(1,0), 32'h10);  wreg(ix(1,1), 32'h20);
    wreg(ix(1,2), 32'd3);   wreg(ix(1,3), 32'h00);
    wreg(ix(3,0), 32'h500); wreg(ix(3,1), 32'h600);
    wreg(ix(3,2), 32'd3);   wreg(ix(3,3), 32'h09);
    pulse(4'b1010); waitc(3);
    rreg(ix(3,0), v); chk("R4 other channel runs", v, 32'h502);
    rreg(ix(3,2), v); chk("R4 other count", v, 2);
    rreg(ix(1,2), v); chk("R4 disabled count held", v, 3);
    rreg(ix(1,3), v); chk("R4 no end flag", v, 0);
  endtask

  task automatic t_global;
    logic [31:0] v;
    int n0;
    n0 = wn;
    wreg(GLOB, 32'h0);
    pulse(4'b1000); waitc(3);
    chk("R5 master off no bus", wn, n0);
    rreg(ix(3,2), v); chk("R5 master off count", v, 2);
    wreg(GLOB, 32'h1); waitc(3);
    rreg(ix(3,2), v); chk("R5 held request served", v, 1);
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    rreg(GLOB, v); chk("R5 nmi flag", v, 32'h5);
    pulse(4'b1000); waitc(3);
    rreg(ix(3,2), v); chk("R5 nmi halts", v, 1);
    rreg(ix(3,3), v); chk("R5 no end flag", v, 32'h09);
    wreg(GLOB, 32'h1); waitc(3);
    rreg(ix(3,2), v); chk("R5 resumed after nmi", v, 0);
    rreg(ix(3,3), v); chk("R3 end flag ch3", v, 32'h0D);
  endtask

  task automatic t_addr_err;
    logic [31:0] v;
    int n0, r0;
    wreg(ix(0,3), 32'h13);
    rreg(ix(0,3), v); chk("R11 end flag cleared by write 0", v, 32'h13);
    chk("R3 irq drops", 32'(irq), 0);
    wreg(ix(0,0), 32'h102); wreg(ix(0,1), 32'h300); wreg(ix(0,2), 32'd2);
    wreg(ix(3,0), 32'h700); wreg(ix(3,1), 32'h800);
    wreg(ix(3,2), 32'd2);   wreg(ix(3,3), 32'h09);
    n0 = wn; r0 = rn;
    pulse(4'b0001); waitc(3);
    chk("R6 no bus read", rn, r0);
    rreg(ix(0,0), v); chk("R6 src frozen", v, 32'h102);
    rreg(ix(0,2), v); chk("R6 count frozen", v, 2);
    rreg(ix(0,3), v); chk("R6 no end flag", v, 32'h13);
    wreg(GLOB, 32'h1);
    rreg(GLOB, v); chk("R7 write without read keeps flag", v, 32'h3);
    pulse(4'b1000);
    wreg(ix(0,0), 32'h100);
    wreg(GLOB, 32'h1);
    rreg(GLOB, v); chk("R7 read then write clears", v, 32'h1);
    waitc(4);
    chk("R8 requests not remembered", wn, n0);
    rreg(ix(3,2), v); chk("R8 ch3 count", v, 2);
    pulse(4'b0001); waitc(3);
    rreg(ix(0,0), v); chk("R8 new request runs", v, 32'h104);
    rreg(ix(0,2), v); chk("R8 new request count", v, 1);
  endtask

  task automatic t_prio;
    logic [31:0] v;
    int n0;
    wreg(ix(2,0), 32'h900); wreg(ix(2,1), 32'hA00);
    wreg(ix(2,2), 32'd1);   wreg(ix(2,3), 32'h01);
    n0 = wn;
    pulse(4'b1100); waitc(6);
    chk("R9 two units", wn, n0 + 2);
    chk("R9 lower channel first", 32'(wlog_a[n0[5:0]]), 32'hA00);
    chk("R9 higher channel second", 32'(wlog_a[6'(n0 + 1)]), 32'h800);
    rreg(ix(2,3), v); chk("R3 ch2 end", v, 32'h05);
    rreg(ix(3,2), v); chk("R9 ch3 count", v, 1);
  endtask

  task automatic t_midunit;
    logic [31:0] v;
    int n0;
    wreg(ix(3,2), 32'd3);
    n0 = wn;
    pulse(4'b1000);
    wreg(ix(3,3), 32'h08);
    waitc(1);
    chk("R10 unit completes write", wn, n0 + 1);
    rreg(ix(3,2), v); chk("R10 count stepped", v, 2);
    rreg(ix(3,0), v); chk("R10 src stepped", v, 32'h704);
    rreg(ix(3,3), v); chk("R4 disabled no flag", v, 32'h08);
    pulse(4'b1000); waitc(3);
    rreg(ix(3,2), v); chk("R4 stays idle", v, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_byte;
    t_disable;
    t_global;
    t_addr_err;
    t_prio;
    t_midunit;
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
      $finish;
    end
  end
endmodule